// File: doc/BRIEF.md
# Serial Channel Word Loader

This block takes a channel number for a frequency synthesizer over a three-wire synchronous serial port: a serial clock, a serial data line and a latch-enable strobe. Every rising edge of the serial clock shifts one data bit into a 7-bit shift register, most significant bit first. A rising edge of the latch-enable copies the shift register into a 7-bit holding register. The holding register drives the synthesizer's swallow count.

The three serial pins are asynchronous to the chip's system clock. Each pin passes through a two-flop synchronizer, and the edges of the serial clock and of the latch-enable are found from the synchronized levels. A channel word is legal when it lies between 0 and 85 and is not 1. An illegal word at latch time leaves the holding register unchanged and sets a sticky error flag. The flag clears only on reset.

Top module: `chan_word_loader`

## Requirements
- R1: While `rst_n` is low at a rising edge of `clk`, `chan_out` becomes 0 and `load_err` becomes 0.
- R2: Each rising edge of `ser_clk` shifts the current `ser_dat` bit into the shift register, first bit into the MSB. A word of more than 7 bits keeps only the last 7 bits sent. The channel 10 example is sent as 0,0,0,1,0,1,0.
- R3: `chan_out` changes only after a rising edge of `ser_le`. Serial clock edges, a falling `ser_le` and a `ser_le` held high have no effect on it.
- R4: A legal word at latch time (0, or 2 to 85) is copied to `chan_out`, and `load_err` is not changed.
- R5: A word of 1 at latch time leaves `chan_out` unchanged and sets `load_err` to 1.
- R6: A word from 86 to 127 at latch time leaves `chan_out` unchanged and sets `load_err` to 1.
- R7: Once `load_err` is 1, it stays 1 until reset, even if legal words are loaded later.
- R8: Pins are sampled at `clk` rising edges. Suppose the edge at cycle n is the first to see `ser_le` (or `ser_clk`) high after a low sample at cycle n-1. Then the resulting register update takes place at the edge of cycle n+2, using the `ser_dat` sample taken at cycle n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_dat | input | 1 | Serial data bit, MSB first, asynchronous |
| ser_le | input | 1 | Latch strobe; a rising edge transfers the word, asynchronous |
| chan_out | output | 7 | Held channel number for the swallow counter |
| load_err | output | 1 | Sticky flag for a rejected channel word |

## Verification
The hardest case to show from the ports is that a rejected word truly leaves the holding register alone. After reset the register already holds 0, so a rejection would look the same as a load of 0. The stimulus therefore first loads a distinct legal channel. It then sends code 1, 86 and 127, and then a legal word that must still load while the error flag stays set. Over-long words of nine bits and a latch strobe with no new data cover the truncation and re-latch cases. The reference model follows the pin sampling cycle by cycle, so each timing slip shows up in the very cycle it happens.

// File: rtl/chan_pkg.sv
// Shared sizing constants for the serial channel word loader.
package chan_pkg;
    localparam int CH_W       = 7;   // channel word width
    localparam int CH_TOP     = 85;  // highest legal channel code
    localparam int CH_SKIP    = 1;   // single forbidden code inside the range
    localparam int SYNC_DEPTH = 2;   // synchronizer flops per pin
endpackage

// File: rtl/pin_sync.sv
// Brings one asynchronous pin into the clk domain through a flop chain.
// WANT_EDGE=0 gives the synchronized level; WANT_EDGE=1 gives a one-cycle
// pulse on a rising transition of that level.
// Assumes: STAGES >= 2; pin pulses last longer than a few clk periods.
module pin_sync #(
    parameter int STAGES    = 2,
    parameter bit WANT_EDGE = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the raw pin through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], pin};
    end

    generate
        if (WANT_EDGE) begin : g_edge
            logic last;
            // Remember the previous synchronized level for edge detection.
            always_ff @(posedge clk) begin
                if (!rst_n) last <= 1'b0;
                else        last <= chain[STAGES-1];
            end
            assign q = chain[STAGES-1] & ~last;

            // R8: a detected rise is a single-cycle pulse
            a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
                q |=> !q);
        end else begin : g_level
            assign q = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/ser_shift.sv
// Serial-in shift register: on each shift pulse the sampled data bit
// enters at the LSB end, so the first bit sent ends up as the MSB.
// Assumes: shift and din are already in the clk domain.
module ser_shift #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift,
    input  logic         din,
    output logic [W-1:0] word
);
    // Move the word one place toward the MSB on each shift pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)     word <= '0;
        else if (shift) word <= {word[W-2:0], din};
    end

    // R2: a shift places the sampled bit at the LSB
    a_r2_bit_enters: assert property (@(posedge clk) disable iff (!rst_n)
        shift |=> word[0] == $past(din));
    // R2: the word holds still without a shift pulse
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !shift |=> $stable(word));
endmodule

// File: rtl/chan_hold.sv
// Holding register for the channel number. On a load pulse it checks the
// word: a legal code is copied, an illegal one is dropped and sets a sticky
// error flag.
// Assumes: load is a single-cycle pulse in the clk domain.
module chan_hold #(
    parameter int W    = 7,
    parameter int TOP  = 85,
    parameter int SKIP = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] word,
    output logic [W-1:0] chan,
    output logic         err
);
    localparam logic [W-1:0] TOP_W  = W'(TOP);
    localparam logic [W-1:0] SKIP_W = W'(SKIP);

    logic legal;

    // Classify the incoming word against the legal channel set.
    always_comb legal = (word <= TOP_W) && (word != SKIP_W);

    // Update the held channel, or record a rejection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan <= '0;
            err  <= 1'b0;
        end else if (load) begin
            if (legal) chan <= word;
            else       err  <= 1'b1;
        end
    end

    // R3: without a load pulse the channel does not move
    a_r3_quiet_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(chan));
    // R5: the forbidden code is dropped and flagged
    a_r5_skip_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (load && word == SKIP_W) |=> ($stable(chan) && err));
    // R6: out-of-range codes are dropped and flagged
    a_r6_range_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (load && word > TOP_W) |=> ($stable(chan) && err));
    // R6: the held channel is always a legal code
    a_r6_chan_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (chan <= TOP_W) && (chan != SKIP_W));
    // R7: the error flag is sticky
    a_r7_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
endmodule

// File: rtl/chan_word_loader.sv
// Top level of the serial channel word loader. It synchronizes the three
// serial pins, shifts data on serial clock rises and moves the word to the
// holding register on latch-enable rises. It rejects illegal codes.
// Assumes: serial high/low phases span several clk periods.
module chan_word_loader
    import chan_pkg::*;
#(
    parameter int W          = CH_W,
    parameter int TOP        = CH_TOP,
    parameter int SKIP       = CH_SKIP,
    parameter int SYNC_STAGE = SYNC_DEPTH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ser_clk,
    input  logic         ser_dat,
    input  logic         ser_le,
    output logic [W-1:0] chan_out,
    output logic         load_err
);
    logic         shift_p;
    logic         dat_s;
    logic         le_p;
    logic [W-1:0] sreg;

    pin_sync #(.STAGES(SYNC_STAGE), .WANT_EDGE(1'b1)) u_clk_sync (
        .clk(clk), .rst_n(rst_n), .pin(ser_clk), .q(shift_p));
    pin_sync #(.STAGES(SYNC_STAGE), .WANT_EDGE(1'b0)) u_dat_sync (
        .clk(clk), .rst_n(rst_n), .pin(ser_dat), .q(dat_s));
    pin_sync #(.STAGES(SYNC_STAGE), .WANT_EDGE(1'b1)) u_le_sync (
        .clk(clk), .rst_n(rst_n), .pin(ser_le), .q(le_p));

    ser_shift #(.W(W)) u_shift (
        .clk(clk), .rst_n(rst_n), .shift(shift_p), .din(dat_s), .word(sreg));

    chan_hold #(.W(W), .TOP(TOP), .SKIP(SKIP)) u_hold (
        .clk(clk), .rst_n(rst_n), .load(le_p), .word(sreg),
        .chan(chan_out), .err(load_err));

    // R1: reset leaves a cleared channel and flag
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (chan_out == '0 && load_err == 1'b0));
endmodule

// File: tb/tb_chan_word_loader.sv
module tb_chan_word_loader;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_clk = 1'b0;
    logic       ser_dat = 1'b0;
    logic       ser_le = 1'b0;
    logic [6:0] chan_out;
    logic       load_err;

    int    total = 0;
    int    bad = 0;
    int    cycles = 0;
    bit    done = 0;
    string cur_req = "R1";

    // behavioural reference state
    int ck_h[4];
    int dt_h[4];
    int le_h[4];
    int m_sreg = 0;
    int m_chan = 0;
    int m_err = 0;

    always #10 clk = ~clk;   // 50 MHz

    chan_word_loader dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .ser_le(ser_le), .chan_out(chan_out), .load_err(load_err));

    // Reference model: pin samples age through a history, edges act two samples later.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin ck_h[i] = 0; dt_h[i] = 0; le_h[i] = 0; end
            m_sreg = 0; m_chan = 0; m_err = 0;
        end else begin
            for (int i = 3; i > 0; i--) begin
                ck_h[i] = ck_h[i-1]; dt_h[i] = dt_h[i-1]; le_h[i] = le_h[i-1];
            end
            ck_h[0] = ser_clk; dt_h[0] = ser_dat; le_h[0] = ser_le;
            if (le_h[2] == 1 && le_h[3] == 0) begin
                if (m_sreg <= 85 && m_sreg != 1) m_chan = m_sreg;
                else m_err = 1;
            end
            if (ck_h[2] == 1 && ck_h[3] == 0)
                m_sreg = ((m_sreg << 1) | dt_h[2]) & 127;
        end
    end

    task automatic check(input string req, input int act, input int exp, input string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d at t=%0t", req, what, act, exp, $time);
        end
    endtask

    // Every-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (!done && rst_n) begin
            check(cur_req, int'(chan_out), m_chan, "chan_out per-cycle");
            check("R7", int'(load_err), m_err, "load_err per-cycle");
        end
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            bad++; total++;
            $display("FAIL watchdog: actual=%0d expected<150000", cycles);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic send_bits(input int val, input int nbits);
        for (int b = nbits - 1; b >= 0; b--) begin
            @(negedge clk); ser_dat = (val >> b) & 1;
            repeat (3) @(negedge clk); ser_clk = 1'b1;
            repeat (8) @(negedge clk); ser_clk = 1'b0;
            repeat (5) @(negedge clk);
        end
    endtask

    task automatic strobe();
        repeat (8) @(negedge clk); ser_le = 1'b1;
        repeat (5) @(negedge clk); ser_le = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check("R1", int'(chan_out), 0, "reset chan");
        check("R1", int'(load_err), 0, "reset err");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        cur_req = "R2";   // channel 10 sent as 0001010, MSB first
        send_bits(10, 7);
        check("R3", int'(chan_out), 0, "no change before strobe");
        strobe();
        check("R2", int'(chan_out), 10, "MSB-first channel 10");

        // R8: exact latency of the strobe
        cur_req = "R8";
        send_bits(33, 7);
        repeat (8) @(negedge clk); ser_le = 1'b1;
        repeat (2) @(negedge clk);
        check("R8", int'(chan_out), 10, "two edges after strobe rise");
        @(negedge clk);
        check("R8", int'(chan_out), 33, "third edge after strobe rise");
        repeat (10) @(negedge clk);
        check("R3", int'(chan_out), 33, "strobe held high");
        ser_le = 1'b0;
        repeat (6) @(negedge clk);
        check("R3", int'(chan_out), 33, "strobe fall");

        cur_req = "R4";
        send_bits(85, 7); strobe();
        check("R4", int'(chan_out), 85, "top code 85");
        send_bits(0, 7); strobe();
        check("R4", int'(chan_out), 0, "code 0");
        send_bits(47, 7); strobe();
        check("R4", int'(chan_out), 47, "code 47");
        check("R4", int'(load_err), 0, "no err on legal loads");

        cur_req = "R5";
        send_bits(1, 7); strobe();
        check("R5", int'(chan_out), 47, "code 1 rejected");
        check("R5", int'(load_err), 1, "code 1 flagged");

        cur_req = "R7";
        send_bits(2, 7); strobe();
        check("R4", int'(chan_out), 2, "code 2 after error");
        check("R7", int'(load_err), 1, "err sticky");

        cur_req = "R6";
        send_bits(86, 7); strobe();
        check("R6", int'(chan_out), 2, "code 86 rejected");
        send_bits(127, 7); strobe();
        check("R6", int'(chan_out), 2, "code 127 rejected");

        // reset clears error, then range reject from clean state
        rst_n = 1'b0; repeat (3) @(negedge clk);
        check("R1", int'(load_err), 0, "err cleared by reset");
        rst_n = 1'b1; repeat (3) @(negedge clk);
        send_bits(60, 7); strobe();
        send_bits(100, 7); strobe();
        check("R6", int'(chan_out), 60, "code 100 rejected");
        check("R6", int'(load_err), 1, "code 100 flagged");

        cur_req = "R2";   // nine bits: leading 1,1 are pushed out, last seven = 42
        send_bits((3 << 7) | 42, 9); strobe();
        check("R2", int'(chan_out), 42, "over-long word keeps last 7");

        cur_req = "R3";   // shifting with no strobe
        send_bits(20, 7);
        repeat (10) @(negedge clk);
        check("R3", int'(chan_out), 42, "shift without strobe");
        strobe();
        check("R3", int'(chan_out), 20, "later strobe loads it");
        strobe();
        check("R3", int'(chan_out), 20, "re-strobe same word");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule